// File: doc/BRIEF.md
# Half-Duplex Serial Transceiver with Echo Rejection

This block is an asynchronous serial transmitter and receiver for a single shared wire or a wired-OR bus. Each word has one low start bit, a programmable number of data bits sent least-significant bit first, and one high stop bit. The length of one bit is a programmable number of clock cycles. The transmitter has one holding slot behind its shift register, so the next word can be queued while the current one is going out. A queued word follows the previous stop bit with no idle time.

A mode word controls four options. It can invert the receive input and the transmit output. It can make the transmitter drive the pad in open-drain fashion, using the output enable while the output value stays low. It can discard the transmitter's own words when they loop back from the bus into the receiver. A bus-direction output is high from the first start bit of a transmit burst until the last stop bit has run its full length. This output can steer an external line driver, and it also marks the window in which echoed words are discarded.

The receiver synchronises the pad and samples each bit at its centre. It delivers each word with a one-cycle strobe. A frame error and a sticky overrun indication accompany the data, and both are held until the host acknowledges the word.

Top module: `hdx_uart`

## Requirements
- R1: When mode bit 0 is set, the receiver treats a low pad level as logic 1 and a high pad level as logic 0. When the bit is clear, pad levels are taken as they are.
- R2: When mode bit 1 is set, the logical transmit level is inverted before it reaches the pad, so an idle push-pull pad drives 0.
- R3: When mode bit 2 is set, `tx_pad_out_o` stays 0. `tx_pad_oe_o` is 1 only while the level after the optional inversion is low. With no inversion, the enable is 0 when the transmitter is idle and during high bits. When mode bit 2 is clear, `tx_pad_oe_o` is 1.
- R4: A transmitted word is a low start bit, then `word_len_i` data bits with bit 0 first, then a high stop bit. Each bit lasts `divisor_i` cycles. Word lengths of 8, 9 and 32 are supported.
- R5: `tx_ready_o` is high while the holding slot is empty. A word written with `tx_load_i` while the slot is full is ignored. A word that is queued when a stop bit ends starts its start bit in the very next cycle, so consecutive start bits are exactly (`word_len_i`+2)·`divisor_i` cycles apart.
- R6: The receiver samples each data bit at its centre. It pulses `rx_valid_o` for one cycle at the centre of the stop bit, delayed only by the input synchroniser, and presents the word on `rx_data_o`.
- R7: A low level on the receive line that has gone high again by half a bit period is not taken as a start bit, and no word is delivered for it.
- R8: `rx_frame_err_o` is set when the stop bit of a delivered word is sampled low. It is cleared when a delivered word has a high stop bit.
- R9: If a word is delivered before the previous one was acknowledged with `rx_ack_i`, `rx_overrun_o` goes high and `rx_data_o` takes the newer word. An acknowledge clears the overrun flag.
- R10: `bus_dir_o` rises with the first start bit of a burst. It falls exactly `divisor_i` cycles after the last stop bit begins, which is (`word_len_i`+2)·`divisor_i` cycles after that word's start bit.
- R11: When mode bit 3 is set, a word whose stop bit is sampled while `bus_dir_o` is high is discarded. It produces no `rx_valid_o`, and `rx_data_o`, `rx_frame_err_o` and `rx_overrun_o` keep their values. When mode bit 3 is clear, echoed words are delivered. Words that arrive after the burst are delivered in either case.
- R12: Mode bits 7 to 4 have no effect on either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 8 | Option bits: 0 invert receive, 1 invert transmit, 2 open-drain, 3 echo rejection |
| divisor_i | input | 16 | Clock cycles per bit |
| word_len_i | input | 6 | Data bits per word |
| tx_data_i | input | 32 | Word to queue, right-aligned |
| tx_load_i | input | 1 | Write strobe for the holding slot |
| tx_ready_o | output | 1 | Holding slot empty |
| tx_pad_out_o | output | 1 | Pad output value |
| tx_pad_oe_o | output | 1 | Pad output enable |
| bus_dir_o | output | 1 | 1 while a transmit burst owns the bus |
| rx_pad_i | input | 1 | Receive pad level |
| rx_data_o | output | 32 | Last delivered word, right-aligned |
| rx_valid_o | output | 1 | One-cycle strobe for a delivered word |
| rx_frame_err_o | output | 1 | Stop bit of the last delivered word was low |
| rx_overrun_o | output | 1 | A word was replaced before it was acknowledged |
| rx_ack_i | input | 1 | Host has read `rx_data_o` |

## Verification
The assertions rely on a few conditions at the inputs. `divisor_i` must be at least 8, so that the centre of a looped-back stop bit falls inside the sender's own stop bit, and so that a delivered word is never followed by another delivery in the next cycle. `word_len_i`, `divisor_i` and `mode_i` must stay constant while a word is in flight. The bench meets these conditions by using a divisor of 16 throughout. It changes word length and mode only after `bus_dir_o` has fallen and the receive line has been idle for at least a bit time. It also raises `tx_load_i` only in cycles where it has seen `tx_ready_o` high.

// File: rtl/hdx_uart_pkg.sv
package hdx_uart_pkg;

   localparam int MODE_W = 8;

   typedef struct packed {
      logic echo_drop;
      logic open_drain;
      logic inv_tx;
      logic inv_rx;
   } hdx_mode_t;

   typedef enum logic [1:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP
   } hdx_rx_state_e;

   // Only the low four bits carry meaning; the rest are dropped here.
   function automatic hdx_mode_t hdx_decode_mode(input logic [MODE_W-1:0] raw);
      hdx_mode_t m;
      m.inv_rx     = raw[0];
      m.inv_tx     = raw[1];
      m.open_drain = raw[2];
      m.echo_drop  = raw[3];
      return m;
   endfunction

endpackage

// File: rtl/hdx_uart_tx.sv
module hdx_uart_tx #(
   parameter int MAX_BITS = 32,
   parameter int DIV_W    = 16,
   localparam int LEN_W   = $clog2(MAX_BITS + 1),
   localparam int POS_W   = $clog2(MAX_BITS + 2)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIV_W-1:0]    divisor_i,
   input  logic [LEN_W-1:0]    word_len_i,
   input  logic [MAX_BITS-1:0] data_i,
   input  logic                load_i,
   output logic                ready_o,
   output logic                active_o,
   output logic                level_o
);

   logic [MAX_BITS-1:0] hold_q;
   logic [MAX_BITS-1:0] shift_q;
   logic                hold_full_q;
   logic                active_q;
   logic [POS_W-1:0]    pos_q;
   logic [DIV_W-1:0]    cnt_q;

   logic             bit_end;
   logic [POS_W-1:0] stop_pos;
   logic             frame_end;
   logic             take;

   assign bit_end   = (cnt_q == divisor_i - DIV_W'(1));
   assign stop_pos  = POS_W'(word_len_i) + POS_W'(1);
   assign frame_end = active_q && bit_end && (pos_q == stop_pos);
   assign take      = hold_full_q && (!active_q || frame_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q      <= '0;
         shift_q     <= '0;
         hold_full_q <= 1'b0;
         active_q    <= 1'b0;
         pos_q       <= '0;
         cnt_q       <= '0;
      end else begin
         if (take) begin
            hold_full_q <= 1'b0;
         end else if (load_i && !hold_full_q) begin
            hold_full_q <= 1'b1;
            hold_q      <= data_i;
         end

         if (take) begin
            active_q <= 1'b1;
            pos_q    <= '0;
            cnt_q    <= '0;
            shift_q  <= hold_q;
         end else if (frame_end) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
         end else if (active_q) begin
            if (bit_end) begin
               cnt_q <= '0;
               pos_q <= pos_q + POS_W'(1);
               if (pos_q != '0) shift_q <= shift_q >> 1;
            end else begin
               cnt_q <= cnt_q + DIV_W'(1);
            end
         end
      end
   end

   always_comb begin
      if (!active_q)                          level_o = 1'b1;
      else if (pos_q == '0)                   level_o = 1'b0;
      else if (pos_q <= POS_W'(word_len_i))   level_o = shift_q[0];
      else                                    level_o = 1'b1;
   end

   assign ready_o  = !hold_full_q;
   assign active_o = active_q;

   // R5: a queued word begins right where the stop bit ends
   assert_gapless_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && hold_full_q) |=> (active_q && pos_q == '0 && cnt_q == '0));

   // R10: the burst ends only on the final cycle of a stop bit
   assert_dir_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active_q) |-> $past(pos_q == stop_pos && bit_end));

endmodule

// File: rtl/hdx_uart_rx.sv
module hdx_uart_rx
   import hdx_uart_pkg::*;
#(
   parameter int MAX_BITS    = 32,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int LEN_W      = $clog2(MAX_BITS + 1),
   localparam int IDX_W      = $clog2(MAX_BITS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [DIV_W-1:0]    divisor_i,
   input  logic [LEN_W-1:0]    word_len_i,
   input  logic                invert_i,
   input  logic                drop_i,
   input  logic                pad_i,
   input  logic                ack_i,
   output logic [MAX_BITS-1:0] data_o,
   output logic                valid_o,
   output logic                frame_err_o,
   output logic                overrun_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
   end

   assign lvl = sync_q[SYNC_STAGES-1] ^ invert_i;

   hdx_rx_state_e       st_q;
   logic [DIV_W-1:0]    cnt_q;
   logic [IDX_W-1:0]    idx_q;
   logic [MAX_BITS-1:0] shreg_q;
   logic [MAX_BITS-1:0] data_q;
   logic                valid_q;
   logic                ferr_q;
   logic                full_q;
   logic                ovr_q;

   logic bit_end;
   logic half_end;
   logic last_bit;

   assign bit_end  = (cnt_q == divisor_i - DIV_W'(1));
   assign half_end = (cnt_q == (divisor_i >> 1) - DIV_W'(1));
   assign last_bit = (LEN_W'(idx_q) == word_len_i - LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= RX_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         shreg_q <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
         ferr_q  <= 1'b0;
         full_q  <= 1'b0;
         ovr_q   <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (ack_i) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
         end
         case (st_q)
            RX_IDLE: begin
               cnt_q <= '0;
               if (!lvl) st_q <= RX_START;
            end
            RX_START: begin
               if (half_end) begin
                  cnt_q <= '0;
                  if (!lvl) begin
                     st_q    <= RX_DATA;
                     idx_q   <= '0;
                     shreg_q <= '0;
                  end else begin
                     st_q <= RX_IDLE;
                  end
               end else begin
                  cnt_q <= cnt_q + DIV_W'(1);
               end
            end
            RX_DATA: begin
               if (bit_end) begin
                  cnt_q          <= '0;
                  shreg_q[idx_q] <= lvl;
                  if (last_bit) st_q  <= RX_STOP;
                  else          idx_q <= idx_q + IDX_W'(1);
               end else begin
                  cnt_q <= cnt_q + DIV_W'(1);
               end
            end
            RX_STOP: begin
               if (bit_end) begin
                  cnt_q <= '0;
                  st_q  <= RX_IDLE;
                  if (!drop_i) begin
                     valid_q <= 1'b1;
                     data_q  <= shreg_q;
                     ferr_q  <= !lvl;
                     full_q  <= 1'b1;
                     if (full_q && !ack_i) ovr_q <= 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q + DIV_W'(1);
               end
            end
            default: st_q <= RX_IDLE;
         endcase
      end
   end

   assign data_o      = data_q;
   assign valid_o     = valid_q;
   assign frame_err_o = ferr_q;
   assign overrun_o   = ovr_q;

   // R6: delivery is a single-cycle strobe
   assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);

   // R9: overrun only appears together with a fresh delivery
   assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_q) |-> valid_q);

   // R8: frame error changes only when a word is delivered
   assert_ferr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_q |-> $stable(ferr_q));

endmodule

// File: rtl/hdx_uart_pad.sv
module hdx_uart_pad #(
   parameter bit ALLOW_OPEN_DRAIN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   input  logic invert_i,
   input  logic open_drain_i,
   output logic out_o,
   output logic oe_o
);

   logic phys;
   assign phys = level_i ^ invert_i;

   if (ALLOW_OPEN_DRAIN) begin : g_od
      always_comb begin
         if (open_drain_i) begin
            out_o = 1'b0;
            oe_o  = !phys;
         end else begin
            out_o = phys;
            oe_o  = 1'b1;
         end
      end

      // R3: open-drain never sources a high level
      assert_od_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
         open_drain_i |-> !out_o);
   end else begin : g_pp
      assign out_o = phys;
      assign oe_o  = 1'b1;
   end

endmodule

// File: rtl/hdx_uart.sv
module hdx_uart
   import hdx_uart_pkg::*;
#(
   parameter int MAX_BITS         = 32,
   parameter int DIV_W            = 16,
   parameter int SYNC_STAGES      = 2,
   parameter bit ALLOW_OPEN_DRAIN = 1'b1,
   localparam int LEN_W           = $clog2(MAX_BITS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [MODE_W-1:0]   mode_i,
   input  logic [DIV_W-1:0]    divisor_i,
   input  logic [LEN_W-1:0]    word_len_i,
   input  logic [MAX_BITS-1:0] tx_data_i,
   input  logic                tx_load_i,
   output logic                tx_ready_o,
   output logic                tx_pad_out_o,
   output logic                tx_pad_oe_o,
   output logic                bus_dir_o,
   input  logic                rx_pad_i,
   output logic [MAX_BITS-1:0] rx_data_o,
   output logic                rx_valid_o,
   output logic                rx_frame_err_o,
   output logic                rx_overrun_o,
   input  logic                rx_ack_i
);

   if (MAX_BITS < 9 || MAX_BITS > 32) begin : g_bad_bits
      $error("hdx_uart: MAX_BITS must lie in 9..32");
   end
   if (DIV_W < 4) begin : g_bad_div
      $error("hdx_uart: DIV_W must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hdx_uart: SYNC_STAGES must be at least 2");
   end

   hdx_mode_t mode;
   logic      tx_level;
   logic      tx_active;

   assign mode = hdx_decode_mode(mode_i);

   hdx_uart_tx #(.MAX_BITS(MAX_BITS), .DIV_W(DIV_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .divisor_i  (divisor_i),
      .word_len_i (word_len_i),
      .data_i     (tx_data_i),
      .load_i     (tx_load_i),
      .ready_o    (tx_ready_o),
      .active_o   (tx_active),
      .level_o    (tx_level)
   );

   hdx_uart_pad #(.ALLOW_OPEN_DRAIN(ALLOW_OPEN_DRAIN)) u_pad (
      .clk          (clk),
      .rst_n        (rst_n),
      .level_i      (tx_level),
      .invert_i     (mode.inv_tx),
      .open_drain_i (mode.open_drain),
      .out_o        (tx_pad_out_o),
      .oe_o         (tx_pad_oe_o)
   );

   hdx_uart_rx #(.MAX_BITS(MAX_BITS), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .divisor_i   (divisor_i),
      .word_len_i  (word_len_i),
      .invert_i    (mode.inv_rx),
      .drop_i      (mode.echo_drop && tx_active),
      .pad_i       (rx_pad_i),
      .ack_i       (rx_ack_i),
      .data_o      (rx_data_o),
      .valid_o     (rx_valid_o),
      .frame_err_o (rx_frame_err_o),
      .overrun_o   (rx_overrun_o)
   );

   assign bus_dir_o = tx_active;

   // R11: nothing is delivered out of a stop sample taken during an own burst
   assert_echo_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |-> !$past(mode_i[3] && bus_dir_o));

   // R3: open-drain, non-inverted, idle line is released
   assert_od_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ALLOW_OPEN_DRAIN && mode_i[2] && !mode_i[1] && !bus_dir_o) |-> !tx_pad_oe_o);

   // R5: the holding slot is never free while a word waits behind an idle shifter
   assert_slot_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_ready_o && !bus_dir_o) |=> bus_dir_o);

endmodule

// File: tb/hdx_uart_tb_top.sv
module hdx_uart_tb_top;

   localparam int DIV  = 16;
   localparam int HALF = DIV / 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  mode = 8'h00;
   logic [15:0] divisor = 16'(DIV);
   logic [5:0]  word_len = 6'd8;
   logic [31:0] tx_data = '0;
   logic        tx_load = 1'b0;
   logic        tx_ready;
   logic        tx_pad_out;
   logic        tx_pad_oe;
   logic        bus_dir;
   logic        rx_pad;
   logic [31:0] rx_data;
   logic        rx_valid;
   logic        rx_frame_err;
   logic        rx_overrun;
   logic        rx_ack = 1'b0;

   logic        loop_en = 1'b0;
   logic        drv_line = 1'b1;
   logic        bus_line;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int valid_cnt = 0;
   int valid_cyc = 0;
   bit finished  = 1'b0;

   logic [31:0] dec_data [4];
   int          dec_start [4];
   int          fall_cyc;

   always #5 clk = ~clk;

   assign bus_line = tx_pad_oe ? tx_pad_out : 1'b1;
   assign rx_pad   = loop_en ? bus_line : drv_line;

   hdx_uart dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_i         (mode),
      .divisor_i      (divisor),
      .word_len_i     (word_len),
      .tx_data_i      (tx_data),
      .tx_load_i      (tx_load),
      .tx_ready_o     (tx_ready),
      .tx_pad_out_o   (tx_pad_out),
      .tx_pad_oe_o    (tx_pad_oe),
      .bus_dir_o      (bus_dir),
      .rx_pad_i       (rx_pad),
      .rx_data_o      (rx_data),
      .rx_valid_o     (rx_valid),
      .rx_frame_err_o (rx_frame_err),
      .rx_overrun_o   (rx_overrun),
      .rx_ack_i       (rx_ack)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rx_valid) begin
         valid_cnt <= valid_cnt + 1;
         valid_cyc <= cyc;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic load_word(input logic [31:0] d);
      while (!tx_ready) @(negedge clk);
      tx_data = d;
      tx_load = 1'b1;
      @(negedge clk);
      tx_load = 1'b0;
   endtask

   task automatic decode_word(input int k, input bit inv);
      logic [31:0] d = '0;
      while ((bus_line ^ inv) !== 1'b0) @(negedge clk);
      dec_start[k] = cyc;
      repeat (HALF) @(negedge clk);
      for (int i = 0; i < int'(word_len); i++) begin
         repeat (DIV) @(negedge clk);
         d[i] = bus_line ^ inv;
      end
      repeat (DIV) @(negedge clk);
      check((bus_line ^ inv) == 1'b1, "R4 stop bit high", 32'(bus_line ^ inv), 32'h1);
      dec_data[k] = d;
   endtask

   task automatic watch_burst_end();
      while (!bus_dir) @(negedge clk);
      while (bus_dir) @(negedge clk);
      fall_cyc = cyc;
   endtask

   task automatic send_and_decode(input int n, input logic [31:0] w0, input logic [31:0] w1,
                                  input logic [31:0] w2, input bit inv);
      fork
         begin
            load_word(w0);
            if (n > 1) load_word(w1);
            if (n > 2) load_word(w2);
         end
         begin
            for (int k = 0; k < n; k++) decode_word(k, inv);
         end
         watch_burst_end();
      join
      @(negedge clk);
   endtask

   task automatic drive_frame(input logic [31:0] d, input int len, input logic stop_v, input logic inv);
      drv_line = 1'b0 ^ inv;
      repeat (DIV) @(negedge clk);
      for (int i = 0; i < len; i++) begin
         drv_line = d[i] ^ inv;
         repeat (DIV) @(negedge clk);
      end
      drv_line = stop_v ^ inv;
      repeat (DIV) @(negedge clk);
      drv_line = 1'b1 ^ inv;
   endtask

   task automatic do_ack();
      rx_ack = 1'b1;
      @(negedge clk);
      rx_ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check(tx_ready == 1'b1, "R5 ready after reset", 32'(tx_ready), 32'h1);
      check(bus_dir == 1'b0, "R10 dir idle after reset", 32'(bus_dir), 32'h0);
      check(tx_pad_out == 1'b1 && tx_pad_oe == 1'b1, "R4 idle line high", {tx_pad_out, tx_pad_oe}, 32'h3);
      check(rx_valid == 1'b0 && rx_overrun == 1'b0 && rx_frame_err == 1'b0,
            "R9 rx flags clear after reset", {rx_valid, rx_overrun, rx_frame_err}, 32'h0);
   endtask

   task automatic t_tx_lengths();
      mode = 8'h00;
      word_len = 6'd8;
      send_and_decode(1, 32'hA5, 0, 0, 1'b0);
      check(dec_data[0] == 32'hA5, "R4 8-bit word", dec_data[0], 32'hA5);
      word_len = 6'd9;
      send_and_decode(1, 32'h1C3, 0, 0, 1'b0);
      check(dec_data[0] == 32'h1C3, "R4 9-bit word", dec_data[0], 32'h1C3);
      word_len = 6'd32;
      send_and_decode(1, 32'hDEADBEEF, 0, 0, 1'b0);
      check(dec_data[0] == 32'hDEADBEEF, "R4 32-bit word", dec_data[0], 32'hDEADBEEF);
      word_len = 6'd8;
   endtask

   task automatic t_gapless();
      int span;
      mode = 8'h00;
      span = (int'(word_len) + 2) * DIV;
      send_and_decode(3, 32'h11, 32'h80, 32'h7E, 1'b0);
      check(dec_data[0] == 32'h11 && dec_data[1] == 32'h80 && dec_data[2] == 32'h7E,
            "R5 burst contents", dec_data[1], 32'h80);
      check(dec_start[1] - dec_start[0] == span, "R5 no gap 1->2", 32'(dec_start[1] - dec_start[0]), 32'(span));
      check(dec_start[2] - dec_start[1] == span, "R5 no gap 2->3", 32'(dec_start[2] - dec_start[1]), 32'(span));
      check(fall_cyc - dec_start[2] == span, "R10 dir released after full stop",
            32'(fall_cyc - dec_start[2]), 32'(span));
   endtask

   task automatic t_ignored_load();
      mode = 8'h00;
      fork
         begin
            load_word(32'h3C);
            load_word(32'h5A);
            tx_data = 32'hFF;
            tx_load = 1'b1;
            @(negedge clk);
            tx_load = 1'b0;
         end
         begin
            decode_word(0, 1'b0);
            decode_word(1, 1'b0);
         end
         watch_burst_end();
      join
      repeat (3 * DIV) @(negedge clk);
      check(dec_data[1] == 32'h5A && bus_dir == 1'b0, "R5 write to full slot ignored", dec_data[1], 32'h5A);
   endtask

   task automatic t_inv_tx();
      mode = 8'h02;
      @(negedge clk);
      check(tx_pad_out == 1'b0, "R2 inverted idle drives 0", 32'(tx_pad_out), 32'h0);
      send_and_decode(1, 32'h96, 0, 0, 1'b1);
      check(dec_data[0] == 32'h96, "R2 inverted word", dec_data[0], 32'h96);
      mode = 8'h00;
   endtask

   task automatic t_open_drain();
      int hi_seen = 0;
      int oe_seen = 0;
      bit stop_mon = 1'b0;
      mode = 8'h04;
      @(negedge clk);
      check(tx_pad_oe == 1'b0 && tx_pad_out == 1'b0, "R3 idle released", {tx_pad_out, tx_pad_oe}, 32'h0);
      fork
         begin
            send_and_decode(1, 32'h4B, 0, 0, 1'b0);
            stop_mon = 1'b1;
         end
         begin
            while (!stop_mon) begin
               @(negedge clk);
               if (tx_pad_out) hi_seen++;
               if (tx_pad_oe) oe_seen++;
            end
         end
      join
      check(dec_data[0] == 32'h4B, "R3 word through pull-up", dec_data[0], 32'h4B);
      check(hi_seen == 0, "R3 output value held low", 32'(hi_seen), 32'h0);
      check(oe_seen > 0, "R3 enable drives low bits", 32'(oe_seen), 32'h1);
      mode = 8'h00;
   endtask

   task automatic t_rx_basic();
      int c0, n0, lat, lo;
      mode = 8'h00;
      word_len = 6'd8;
      n0 = valid_cnt;
      c0 = cyc;
      drive_frame(32'h3C, 8, 1'b1, 1'b0);
      repeat (2 * DIV) @(negedge clk);
      lat = valid_cyc - c0;
      lo  = HALF + 9 * DIV;
      check(valid_cnt == n0 + 1 && rx_data == 32'h3C, "R6 word received", rx_data, 32'h3C);
      check(lat >= lo && lat <= lo + 4, "R6 strobe at stop centre", 32'(lat), 32'(lo));
      do_ack();
      word_len = 6'd9;
      n0 = valid_cnt;
      drive_frame(32'h155, 9, 1'b1, 1'b0);
      repeat (2 * DIV) @(negedge clk);
      check(valid_cnt == n0 + 1 && rx_data == 32'h155, "R6 9-bit word received", rx_data, 32'h155);
      do_ack();
      word_len = 6'd8;
   endtask

   task automatic t_inv_rx();
      int n0;
      mode = 8'h01;
      drv_line = 1'b0;
      repeat (3 * DIV) @(negedge clk);
      n0 = valid_cnt;
      drive_frame(32'hC1, 8, 1'b1, 1'b1);
      repeat (2 * DIV) @(negedge clk);
      check(valid_cnt == n0 + 1 && rx_data == 32'hC1, "R1 inverted receive", rx_data, 32'hC1);
      do_ack();
      mode = 8'h00;
      drv_line = 1'b1;
      repeat (3 * DIV) @(negedge clk);
   endtask

   task automatic t_false_start();
      int n0;
      n0 = valid_cnt;
      drv_line = 1'b0;
      repeat (DIV / 4) @(negedge clk);
      drv_line = 1'b1;
      repeat (12 * DIV) @(negedge clk);
      check(valid_cnt == n0, "R7 short glitch rejected", 32'(valid_cnt - n0), 32'h0);
      drive_frame(32'h69, 8, 1'b1, 1'b0);
      repeat (2 * DIV) @(negedge clk);
      check(valid_cnt == n0 + 1 && rx_data == 32'h69, "R7 recovery after glitch", rx_data, 32'h69);
      do_ack();
   endtask

   task automatic t_frame_err();
      int n0;
      n0 = valid_cnt;
      drive_frame(32'h24, 8, 1'b0, 1'b0);
      repeat (3 * DIV) @(negedge clk);
      check(rx_frame_err == 1'b1 && rx_data == 32'h24, "R8 low stop flagged", 32'(rx_frame_err), 32'h1);
      check(valid_cnt == n0 + 1, "R8 bad word still delivered once", 32'(valid_cnt - n0), 32'h1);
      do_ack();
      drive_frame(32'h42, 8, 1'b1, 1'b0);
      repeat (2 * DIV) @(negedge clk);
      check(rx_frame_err == 1'b0 && rx_data == 32'h42, "R8 good stop clears flag", 32'(rx_frame_err), 32'h0);
      do_ack();
   endtask

   task automatic t_overrun();
      drive_frame(32'h0F, 8, 1'b1, 1'b0);
      repeat (DIV) @(negedge clk);
      check(rx_overrun == 1'b0, "R9 first word no overrun", 32'(rx_overrun), 32'h0);
      drive_frame(32'hF0, 8, 1'b1, 1'b0);
      repeat (2 * DIV) @(negedge clk);
      check(rx_overrun == 1'b1 && rx_data == 32'hF0, "R9 overrun with newer data", rx_data, 32'hF0);
      do_ack();
      check(rx_overrun == 1'b0, "R9 ack clears overrun", 32'(rx_overrun), 32'h0);
   endtask

   task automatic t_echo();
      int n0;
      logic [31:0] held;
      held = rx_data;
      loop_en = 1'b1;
      mode = 8'h08;
      n0 = valid_cnt;
      send_and_decode(2, 32'hAA, 32'h33, 0, 1'b0);
      repeat (2 * DIV) @(negedge clk);
      check(valid_cnt == n0, "R11 own burst discarded", 32'(valid_cnt - n0), 32'h0);
      check(rx_data == held && rx_overrun == 1'b0, "R11 receive state untouched", rx_data, held);
      loop_en = 1'b0;
      drive_frame(32'h77, 8, 1'b1, 1'b0);
      repeat (2 * DIV) @(negedge clk);
      check(valid_cnt == n0 + 1 && rx_data == 32'h77, "R11 word after burst delivered", rx_data, 32'h77);
      do_ack();
      loop_en = 1'b1;
      mode = 8'h00;
      n0 = valid_cnt;
      send_and_decode(1, 32'h5A, 0, 0, 1'b0);
      repeat (2 * DIV) @(negedge clk);
      check(valid_cnt == n0 + 1 && rx_data == 32'h5A, "R11 echo kept when disabled", rx_data, 32'h5A);
      do_ack();
      loop_en = 1'b0;
      repeat (2 * DIV) @(negedge clk);
   endtask

   task automatic t_high_bits();
      int n0;
      mode = 8'hF0;
      @(negedge clk);
      check(tx_pad_out == 1'b1 && tx_pad_oe == 1'b1, "R12 upper bits leave pad plain",
            {tx_pad_out, tx_pad_oe}, 32'h3);
      send_and_decode(1, 32'hB2, 0, 0, 1'b0);
      check(dec_data[0] == 32'hB2, "R12 transmit unaffected", dec_data[0], 32'hB2);
      n0 = valid_cnt;
      drive_frame(32'h2B, 8, 1'b1, 1'b0);
      repeat (2 * DIV) @(negedge clk);
      check(valid_cnt == n0 + 1 && rx_data == 32'h2B, "R12 receive unaffected", rx_data, 32'h2B);
      do_ack();
      mode = 8'h00;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_tx_lengths();
      t_gapless();
      t_ignored_load();
      t_inv_tx();
      t_open_drain();
      t_rx_basic();
      t_inv_rx();
      t_false_start();
      t_frame_err();
      t_overrun();
      t_echo();
      t_high_bits();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=done", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule